// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider Controller

This block sits behind an external two-ratio prescaler and turns it into a programmable divider. Each pulse from the prescaler output advances two down-counters together: a main counter loaded with N, and a shorter swallow counter loaded with A. While the swallow counter is still running, the modulus-control output stays low, so the prescaler divides by P+1. Once the swallow counter is spent, the control output goes high and the prescaler divides by P for the rest of the main count. The total division from the prescaler input to the divided output is then N·P + A.

When the main counter finishes, the block raises a one-clock divided-output pulse in the same clock as the strobe that ends the count. Both counters then reload, and the control output returns to its start-of-cycle level. The programmed N and A are read only at a reload. They may therefore be rewritten at any time without disturbing the cycle in progress. The configuration must keep N ≥ 1 and A ≤ N.

Top module: `swallow_divider`

## Requirements
- R1: A synchronous reset loads both counters from `n_val` and `a_val`. Before the first strobe after reset, `mod_ctl` is 0 when A > 0 and 1 when A = 0, and `fv_pulse` is 0.
- R2: Within a divide cycle, `mod_ctl` is 0 while strobes 1 to A of the cycle are present and 1 while strobes A+1 to N are present. `mod_ctl` falls only in the clock after a `fv_pulse`.
- R3: `fv_pulse` is 1 in exactly the clock in which the Nth strobe of a cycle is present, and in no other clock.
- R4: If a prescaler divides by P+1 while `mod_ctl` is 0 and by P while it is 1, then the input clocks counted between successive `fv_pulse` events equal N·P + A.
- R5: With A = 0, `mod_ctl` stays 1 for the whole cycle.
- R6: With A = N, `mod_ctl` stays 0 for the whole cycle, including across the reload.
- R7: A change to `n_val` or `a_val` in the middle of a cycle has no effect until the next reload. The following cycle uses the values present at that reload.
- R8: In a clock without a strobe, `mod_ctl` keeps its value into the next clock and `fv_pulse` is 0.
- R9: With N = 1, every strobe produces `fv_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high; reloads both counters |
| pre_tick | input | 1 | One-clock strobe from the prescaler output |
| n_val | input | NW | Programmed main count N |
| a_val | input | AW | Programmed swallow count A |
| mod_ctl | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| fv_pulse | output | 1 | Divided output, one clock per complete cycle |

## Verification
The checker assumes three things about the inputs. The configuration keeps A ≤ N and N ≥ 1. `a_val` holds its value in the clock of a wrap, so the reload value can be compared with it. Strobes are single-clock events supplied by a prescaler model. The bench meets these assumptions by choosing every first and second configuration with A no larger than N. It changes both programmed values together at a falling edge, and it generates strobes from a prescaler model whose ratio follows the observed `mod_ctl`, with at least two clocks between strobes.

// File: rtl/swd_pkg.sv
package swd_pkg;
   typedef enum logic [0:0] {
      CNT_WRAP = 1'b0,
      CNT_SAT  = 1'b1
   } cnt_mode_e;

   localparam int unsigned MIN_MAIN_W = 2;
endpackage

// File: rtl/swd_down_counter.sv
module swd_down_counter #(
   parameter int unsigned        W    = 8,
   parameter swd_pkg::cnt_mode_e MODE = swd_pkg::CNT_WRAP
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         reload,
   output logic [W-1:0] cnt,
   output logic         at_zero,
   output logic         at_one
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] nxt;

   generate
      if (MODE == swd_pkg::CNT_SAT) begin : g_sat
         always_comb nxt = (cnt == '0) ? cnt : cnt - ONE;
      end else begin : g_wrap
         always_comb nxt = cnt - ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || reload) cnt <= load_val;
      else if (step)     cnt <= nxt;
   end

   assign at_zero = (cnt == '0);
   assign at_one  = (cnt == ONE);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
   parameter int unsigned NW = 10,
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pre_tick,
   input  logic [NW-1:0] n_val,
   input  logic [AW-1:0] a_val,
   output logic          mod_ctl,
   output logic          fv_pulse
);
   generate
      if (NW < swd_pkg::MIN_MAIN_W) begin : g_bad_nw
         $error("swallow_divider: NW too small");
      end
      if (AW < 1 || AW > NW) begin : g_bad_aw
         $error("swallow_divider: AW must be 1..NW");
      end
   endgenerate

   logic [NW-1:0] n_cnt;
   logic [AW-1:0] a_cnt;
   logic          n_zero, n_one;
   logic          a_zero, a_one;
   logic          wrap;

   // wrap: the strobe that finishes the main count reloads both counters
   assign wrap = pre_tick & (n_one | n_zero);

   swd_down_counter #(.W(NW), .MODE(swd_pkg::CNT_WRAP)) u_main (
      .clk(clk), .rst(rst), .load_val(n_val), .step(pre_tick),
      .reload(wrap), .cnt(n_cnt), .at_zero(n_zero), .at_one(n_one)
   );

   swd_down_counter #(.W(AW), .MODE(swd_pkg::CNT_SAT)) u_swallow (
      .clk(clk), .rst(rst), .load_val(a_val), .step(pre_tick),
      .reload(wrap), .cnt(a_cnt), .at_zero(a_zero), .at_one(a_one)
   );

   assign mod_ctl  = a_zero;
   assign fv_pulse = wrap;

   logic unused_ok;
   assign unused_ok = a_one;
endmodule

module swallow_divider_chk #(
   parameter int unsigned NW = 10,
   parameter int unsigned AW = 7
) (
   input logic          clk,
   input logic          rst,
   input logic          pre_tick,
   input logic [AW-1:0] a_val,
   input logic          mod_ctl,
   input logic          fv_pulse,
   input logic [NW-1:0] n_cnt,
   input logic [AW-1:0] a_cnt
);
   logic live;
   always_ff @(posedge clk) live <= !rst;

   AST_FV_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      fv_pulse |-> pre_tick); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !pre_tick |=> $stable(mod_ctl)); // R8
   AST_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
      (fv_pulse && a_val != '0) |=> !mod_ctl); // R2
   AST_A0_HIGH: assert property (@(posedge clk) disable iff (rst)
      (fv_pulse && a_val == '0) |=> mod_ctl); // R5
   AST_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
      (live && $fell(mod_ctl)) |-> $past(fv_pulse)); // R2
   AST_SWALLOW_LE_MAIN: assert property (@(posedge clk) disable iff (rst)
      live |-> (NW'(a_cnt) <= n_cnt)); // R2
endmodule

bind swallow_divider swallow_divider_chk #(.NW(NW), .AW(AW)) i_chk (
   .clk(clk), .rst(rst), .pre_tick(pre_tick), .a_val(a_val),
   .mod_ctl(mod_ctl), .fv_pulse(fv_pulse), .n_cnt(n_cnt), .a_cnt(a_cnt)
);

// File: tb/test_swallow_divider.sv
module test_swallow_divider;
   localparam int NW = 4;
   localparam int AW = 3;
   localparam int P  = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          pre_tick = 1'b0;
   logic [NW-1:0] n_val = '0;
   logic [AW-1:0] a_val = '0;
   logic          mod_ctl, fv_pulse;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   swallow_divider #(.NW(NW), .AW(AW)) i_swallow_divider (
      .clk(clk), .rst(rst), .pre_tick(pre_tick), .n_val(n_val),
      .a_val(a_val), .mod_ctl(mod_ctl), .fv_pulse(fv_pulse)
   );

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d (N=%0d A=%0d)", tag, act, exp, n_val, a_val);
      end
   endtask

   task automatic run_case(int n, int a, int n2, int a2);
      int cur_n, cur_a, old_n, old_a, clocks, r;
      int hold;
      string mtag, ftag;
      @(negedge clk);
      n_val = NW'(n); a_val = AW'(a); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 mod_ctl", int'(mod_ctl), (a == 0) ? 1 : 0);
      chk("R1 fv_pulse", int'(fv_pulse), 0);
      @(negedge clk);
      cur_n = n; cur_a = a;
      for (int cyc = 0; cyc < 3; cyc++) begin
         clocks = 0; old_n = cur_n; old_a = cur_a;
         for (int k = 0; k < old_n; k++) begin
            if (cyc == 0 && k == 1) begin
               n_val = NW'(n2); a_val = AW'(a2);
            end
            pre_tick = 1'b1;
            #1;
            if (cyc > 0 && (n2 != n || a2 != a)) mtag = "R7 mod_ctl";
            else if (old_a == 0)                 mtag = "R5 mod_ctl";
            else if (old_a == old_n)             mtag = "R6 mod_ctl";
            else                                 mtag = "R2 mod_ctl";
            ftag = (old_n == 1) ? "R9 fv_pulse" : "R3 fv_pulse";
            chk(mtag, int'(mod_ctl), (k >= old_a) ? 1 : 0);
            chk(ftag, int'(fv_pulse), (k == old_n - 1) ? 1 : 0);
            r = mod_ctl ? P : P + 1;
            clocks += r;
            @(negedge clk);
            pre_tick = 1'b0;
            if (k == old_n - 1) begin
               cur_n = int'(n_val); cur_a = int'(a_val);
               hold = (cur_a == 0) ? 1 : 0;
            end else begin
               hold = (k + 1 >= old_a) ? 1 : 0;
            end
            for (int g = 1; g < r; g++) begin
               #1;
               chk("R8 mod_ctl hold", int'(mod_ctl), hold);
               chk("R8 fv_pulse idle", int'(fv_pulse), 0);
               @(negedge clk);
            end
         end
         chk("R4 clocks per cycle", clocks, old_n * P + old_a);
      end
   endtask

   initial begin
      int n2, a2;
      for (int n = 1; n <= 9; n++) begin
         for (int a = 0; a <= n && a <= 7; a++) begin
            n2 = (n % 4) + 2;
            a2 = (a + 1) % (n2 + 1);
            run_case(n, a, n2, a2);
         end
      end
      run_case(1, 0, 1, 0);
      run_case(1, 1, 1, 1);
      run_case(7, 7, 7, 7);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule